// File: doc/BRIEF.md
# Mailbox Interrupt Flag Logic

This block produces the port-to-port interrupt signals that sit beside a two-port shared memory. The two highest word addresses of the memory serve as mailboxes: the very top word is the mailbox owned by port B, and the word just below it is the mailbox owned by port A. When one port writes into the mailbox owned by the other port, that other port's interrupt output goes low. The port that owns a mailbox clears its own interrupt by reading that mailbox. The mailbox words stay ordinary storage in the memory. This logic only watches the access cycles and does not touch the data.

Each port presents an address, a chip enable, a write strobe (1 = write, 0 = read) and a semaphore select. An access counts only when the chip enable is high and the semaphore select is low. Both flags are registered and update on the clock edge at which the qualifying access is sampled. The address width parameter picks the memory depth, and the two mailbox addresses follow from it. A 15-bit address gives 7FFF and 7FFE. A 16-bit address gives FFFF and FFFE.

Top module: `mbx_irq_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, both a_irq_n and b_irq_n are high (no interrupt pending).
- R2: A qualified port-A write to the top address (all address bits 1, 7FFF at ADDR_W=15) drives b_irq_n low after that clock edge.
- R3: A qualified port-B read of the top address drives b_irq_n high after that edge, unless R7 applies.
- R4: A qualified port-B write to the top address minus one (7FFE at ADDR_W=15) drives a_irq_n low after that edge.
- R5: A qualified port-A read of the top address minus one drives a_irq_n high after that edge, unless R7 applies.
- R6: An access is ignored when its chip enable (x_en) is 0 or its semaphore select (x_sem) is 1.
- R7: When a set and a clear reach the same flag in one cycle, the flag is set (its output goes low).
- R8: Some accesses leave both outputs unchanged: a port writing its own mailbox, a port reading the other port's mailbox, and any access to any other address.
- R9: With no set or clear event, each interrupt output holds its value from cycle to cycle.
- R10: Only the two mailbox addresses derived from ADDR_W act as mailboxes. At ADDR_W=15 an access to 7FFD has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_en | input | 1 | Port A chip enable, active high |
| a_we | input | 1 | Port A direction: 1 write, 0 read |
| a_sem | input | 1 | Port A semaphore select; 1 disqualifies the access |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_en | input | 1 | Port B chip enable, active high |
| b_we | input | 1 | Port B direction: 1 write, 0 read |
| b_sem | input | 1 | Port B semaphore select; 1 disqualifies the access |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
A directed sequence walks through each mailbox role in turn:
- posting to the peer and fetching by the owner;
- writing one's own mailbox and reading the peer's mailbox, which separates "any mailbox access" from the correct direction;
- the neighbouring address 7FFD, which shows that the decode is exact;
- a disabled enable and an active semaphore select, which show that accesses are qualified;
- a post and a fetch on the same flag in one cycle, which shows that the set wins.

After that, thousands of seeded random cycles are run on both ports at once. The addresses are biased toward the top two words, so that simultaneous posts, fetches and reads of the wrong mailbox occur often. A bench flag model checks the two outputs after every edge.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  // Mailbox word owned by port B: the highest word of the array.
  function automatic logic [31:0] box_of_b(input int unsigned aw);
    logic [31:0] v;
    v = (32'd1 << aw) - 32'd1;
    return v;
  endfunction

  // Mailbox word owned by port A: one below the highest word.
  function automatic logic [31:0] box_of_a(input int unsigned aw);
    logic [31:0] v;
    v = (32'd1 << aw) - 32'd2;
    return v;
  endfunction

  // An access counts only with enable high and semaphore select low.
  function automatic logic qualified(input logic en, input logic sem);
    return en & ~sem;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '0,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              we,
  input  logic              sem,
  output logic              post_peer,
  output logic              fetch_own
);

  logic live;
  dir_e dir;

  always_comb begin
    live      = qualified(en, sem);
    dir       = dir_e'(we);
    post_peer = live && (dir == DIR_WRITE) && (addr == PEER_BOX);
    fetch_own = live && (dir == DIR_READ)  && (addr == OWN_BOX);
  end

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic irq_n
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_ev)  pending <= 1'b1;
    else if (clr_ev)  pending <= 1'b0;
  end

  assign irq_n = ~pending;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && clr_ev) |=> !irq_n);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_sem,
  output logic              a_irq_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_sem,
  output logic              b_irq_n
);

  localparam int unsigned NPORT = 2;
  localparam logic [31:0] BOX_A_W = box_of_a(ADDR_W);
  localparam logic [31:0] BOX_B_W = box_of_b(ADDR_W);
  localparam logic [ADDR_W-1:0] BOX_A = BOX_A_W[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] BOX_B = BOX_B_W[ADDR_W-1:0];

  logic [ADDR_W-1:0] addr_v [NPORT];
  logic [NPORT-1:0]  en_v, we_v, sem_v;
  logic [NPORT-1:0]  post_peer, fetch_own, irq_n_v;

  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;
  assign en_v      = {b_en, a_en};
  assign we_v      = {b_we, a_we};
  assign sem_v     = {b_sem, a_sem};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_A : BOX_B;
    localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_B : BOX_A;

    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .addr     (addr_v[p]),
      .en       (en_v[p]),
      .we       (we_v[p]),
      .sem      (sem_v[p]),
      .post_peer(post_peer[p]),
      .fetch_own(fetch_own[p])
    );

    mbx_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_ev(post_peer[NPORT-1-p]),
      .clr_ev(fetch_own[p]),
      .irq_n (irq_n_v[p])
    );
  end

  assign a_irq_n = irq_n_v[0];
  assign b_irq_n = irq_n_v[1];

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (a_irq_n && b_irq_n));

  assert_post_to_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !a_sem && a_we && a_addr == BOX_B) |=> !b_irq_n);

  assert_fetch_by_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && !b_sem && !b_we && b_addr == BOX_B && !post_peer[0]) |=> b_irq_n);

  assert_post_to_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && !b_sem && b_we && b_addr == BOX_A) |=> !a_irq_n);

  assert_fetch_by_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !a_sem && !a_we && a_addr == BOX_A && !post_peer[1]) |=> a_irq_n);

  assert_gate_a_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!a_en || a_sem) && !post_peer[1]) |=> $stable(a_irq_n));

  assert_gate_b_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!b_en || b_sem) && !post_peer[0]) |=> $stable(b_irq_n));

  assert_own_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && a_addr != BOX_B && !fetch_own[1] && !post_peer[0]
     && (!b_en || b_sem || b_addr != BOX_B)) |=> $stable(b_irq_n));

endmodule

// File: tb/mbx_irq_top_test.sv
`timescale 1ns/1ps
module mbx_irq_top_test;

  localparam int unsigned AW = 15;
  localparam int unsigned TOP  = (1 << AW) - 1;
  localparam int unsigned NEXT = (1 << AW) - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_en = 0, a_we = 0, a_sem = 0, b_en = 0, b_we = 0, b_sem = 0;
  logic a_irq_n, b_irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_a  = 0;  // model: interrupt pending on port A
  bit exp_b  = 0;

  always #2.5 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_en(a_en), .a_we(a_we), .a_sem(a_sem), .a_irq_n(a_irq_n),
    .b_addr(b_addr), .b_en(b_en), .b_we(b_we), .b_sem(b_sem), .b_irq_n(b_irq_n)
  );

  function automatic bit hits(int unsigned addr, bit en, bit sem, bit we,
                              bit want_we, int unsigned target);
    return en && !sem && (we == want_we) && (addr == target);
  endfunction

  function automatic bit flag_next(bit cur, bit set, bit clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int unsigned aa, bit ae, bit aw, bit as,
                     int unsigned ba, bit be, bit bw, bit bs);
    bit sa, ca, sb, cb;
    @(negedge clk);
    a_addr = aa[AW-1:0]; a_en = ae; a_we = aw; a_sem = as;
    b_addr = ba[AW-1:0]; b_en = be; b_we = bw; b_sem = bs;
    sb = hits(aa, ae, as, aw, 1'b1, TOP);
    cb = hits(ba, be, bs, bw, 1'b0, TOP);
    sa = hits(ba, be, bs, bw, 1'b1, NEXT);
    ca = hits(aa, ae, as, aw, 1'b0, NEXT);
    exp_a = flag_next(exp_a, sa, ca);
    exp_b = flag_next(exp_b, sb, cb);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    a_en = 0; b_en = 0;
    exp_a = 0; exp_b = 0;
    @(posedge clk); #1;
    check("R1 a in reset", a_irq_n, 1'b1);
    check("R1 b in reset", b_irq_n, 1'b1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 a after reset", a_irq_n, 1'b1);
    check("R1 b after reset", b_irq_n, 1'b1);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    do_reset();

    // R2: A posts to B
    cyc(TOP, 1, 1, 0, 0, 0, 0, 0);
    check("R2 b set", b_irq_n, 1'b0);
    check("R2 a untouched", a_irq_n, 1'b1);
    idle();
    check("R9 b holds", b_irq_n, 1'b0);
    // R8: A reads B's box, B writes own box
    cyc(TOP, 1, 0, 0, 0, 0, 0, 0);
    check("R8 peer-box read", b_irq_n, 1'b0);
    cyc(0, 0, 0, 0, TOP, 1, 1, 0);
    check("R8 own-box write", b_irq_n, 1'b0);
    // R6: disqualified reads
    cyc(0, 0, 0, 0, TOP, 0, 0, 0);
    check("R6 enable low", b_irq_n, 1'b0);
    cyc(0, 0, 0, 0, TOP, 1, 0, 1);
    check("R6 semaphore select", b_irq_n, 1'b0);
    // R3: B fetches
    cyc(0, 0, 0, 0, TOP, 1, 0, 0);
    check("R3 b cleared", b_irq_n, 1'b1);
    // R4: B posts to A at 7FFE
    cyc(0, 0, 0, 0, NEXT, 1, 1, 0);
    check("R4 a set", a_irq_n, 1'b0);
    check("R4 b untouched", b_irq_n, 1'b1);
    cyc(NEXT, 1, 1, 0, 0, 0, 0, 0);
    check("R8 a own-box write", a_irq_n, 1'b0);
    // R10: neighbouring word is not a mailbox
    cyc(NEXT - 1, 1, 0, 0, NEXT - 1, 1, 1, 0);
    check("R10 7FFD read a", a_irq_n, 1'b0);
    check("R10 7FFD write b", b_irq_n, 1'b1);
    // R7: set and clear of A together
    cyc(NEXT, 1, 0, 0, NEXT, 1, 1, 0);
    check("R7 a set wins", a_irq_n, 1'b0);
    // R5: A fetches
    cyc(NEXT, 1, 0, 0, 0, 0, 0, 0);
    check("R5 a cleared", a_irq_n, 1'b1);
    // R6: disqualified post
    cyc(TOP, 1, 1, 1, 0, 0, 0, 0);
    check("R6 sem blocks post", b_irq_n, 1'b1);
    cyc(TOP, 0, 1, 0, 0, 0, 0, 0);
    check("R6 enable blocks post", b_irq_n, 1'b1);
    // R7: set and clear of B together
    cyc(TOP, 1, 1, 0, TOP, 1, 0, 0);
    check("R7 b set wins", b_irq_n, 1'b0);
    cyc(NEXT, 1, 0, 0, TOP, 1, 0, 0);
    check("R3 b cleared again", b_irq_n, 1'b1);
    check("R5 a stays clear", a_irq_n, 1'b1);
    // R1: reset with both pending
    cyc(TOP, 1, 1, 0, NEXT, 1, 1, 0);
    check("R2 b set before reset", b_irq_n, 1'b0);
    check("R4 a set before reset", a_irq_n, 1'b0);
    do_reset();

    // Random phase against the bench model (R9 and all event rules)
    for (int i = 0; i < 4000; i++) begin
      int unsigned aa, ba;
      bit ae, aw, as, be, bw, bs;
      aa = ($urandom % 4 != 0) ? (TOP - ($urandom % 2)) : ($urandom % (1 << AW));
      ba = ($urandom % 4 != 0) ? (TOP - ($urandom % 2)) : ($urandom % (1 << AW));
      ae = ($urandom % 8) != 0;  be = ($urandom % 8) != 0;
      as = ($urandom % 8) == 0;  bs = ($urandom % 8) == 0;
      aw = $urandom % 2;         bw = $urandom % 2;
      cyc(aa, ae, aw, as, ba, be, bw, bs);
      check("R9 random a", a_irq_n, ~exp_a);
      check("R9 random b", b_irq_n, ~exp_b);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule